// File: doc/BRIEF.md
# Variable-Length Address Delta Encoder with Run Folding

This block turns a stream of reference addresses into a compact byte stream. For each address it takes the difference from the previous address and writes that difference with as few bytes as the value allows. A difference of exactly 4 is the usual step of sequential code, so it is carried in the header alone. When the same difference occurs several times in a row, the references are folded into one record that carries a count, so a long strided walk costs only a few bytes.

Addresses arrive on a valid/ready handshake, and encoded bytes leave on a second valid/ready handshake, one byte per transfer. A record is a header byte, then a count byte when the record covers more than one reference, then 0, 1, 2 or 4 offset bytes. A run stays open, with no output, until one of three events closes it: a different difference arrives, the run reaches its maximum length, or the flush input is raised. A consumer that knows the previous address (zero after reset) can rebuild every address from the records.

Top module: `delta_stream_encoder`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the previous address is 0, so the first address taken is encoded as its difference from zero.
- R2: A header byte has the size code in bits [1:0] (0 = no offset bytes, 1 = one byte, 2 = two bytes, 3 = four bytes), the repeat flag in bit 2, and zeros in bits [7:3].
- R3: A difference of exactly +4 uses size code 0 and is followed by no offset bytes.
- R4: A difference d with -127 <= d <= 127 uses one offset byte (code 1). Otherwise, a difference with -32768 <= d <= 32767 uses two bytes (code 2).
- R5: Any other difference uses four bytes (code 3). Offset bytes are the two's complement value, least significant byte first.
- R6: N consecutive references (2 <= N) with the same difference form one record: the header has bit 2 set, the next byte is N, and the offset bytes for that difference follow.
- R7: A record that covers a single reference has bit 2 clear and no count byte.
- R8: When a run reaches RUN_MAX references (255 by default), its record is emitted at once, with the header on out_byte in the cycle after the clock edge that takes the last reference. The next reference starts a new run.
- R9: Flush, taken in a cycle where in_ready is 1 and in_valid is 0, emits the open record. A flush with no open record emits nothing.
- R10: While out_valid is 1 and out_ready is 0, out_byte and out_valid hold. in_ready is 0 while a record is being sent.
- R11: A reference whose difference matches the open run produces no output. A reference with a new difference emits the previous run's record, with the header on out_byte in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An address is presented |
| in_ready | output | 1 | The encoder can take an address or a flush |
| in_addr | input | ADDR_W | Reference address |
| flush | input | 1 | Close the open run (taken when in_ready=1 and in_valid=0) |
| out_valid | output | 1 | out_byte holds an encoded byte |
| out_ready | input | 1 | The consumer takes out_byte |
| out_byte | output | 8 | Encoded byte stream |

## Verification
A wrong previous-address value shifts every later difference, so it shows up in the offset bytes of the next record that is emitted. A wrong run count or an open-run flag that fails to clear shows up as a bad count byte, a missing record, or an extra record, at the latest when the next differing reference or flush closes the run. Errors in the size choice or in byte order show up in the header or offset bytes of the same record, which appears one cycle after the closing event. The tests therefore compare the whole byte stream against a model built from the requirements. Separate checks cover when the header first appears and whether bytes hold while out_ready is low.

// File: rtl/dve_pkg.sv
package dve_pkg;

  typedef logic signed [31:0] off32_t;

  typedef enum logic [1:0] {
    SZ_SEQ = 2'd0,
    SZ_B1  = 2'd1,
    SZ_B2  = 2'd2,
    SZ_B4  = 2'd3
  } size_code_e;

  localparam int unsigned REC_MAX_BYTES = 6;

  function automatic size_code_e size_of(input off32_t o);
    if (o == 32'sd4)                          return SZ_SEQ;
    else if (o >= -32'sd127 && o <= 32'sd127) return SZ_B1;
    else if (o >= -32'sd32768 && o <= 32'sd32767) return SZ_B2;
    else                                      return SZ_B4;
  endfunction

  function automatic logic [2:0] offset_bytes(input size_code_e c);
    case (c)
      SZ_SEQ:  return 3'd0;
      SZ_B1:   return 3'd1;
      SZ_B2:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dve_run_tracker.sv
module dve_run_tracker
  import dve_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int RUN_MAX = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              flush_take,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              emit_valid,
  output off32_t            emit_off,
  output logic [7:0]        emit_cnt
);

  localparam logic [7:0] CNT_LIMIT = 8'(RUN_MAX);

  logic [ADDR_W-1:0] prev_addr;
  logic              run_open;
  off32_t            run_off;
  logic [7:0]        run_cnt;

  logic [ADDR_W-1:0] diff;
  off32_t            cur_off;
  logic              same_off;
  logic [7:0]        cnt_next;
  logic              hit_limit;

  assign diff      = in_addr - prev_addr;
  assign cur_off   = 32'(signed'(diff));
  assign same_off  = run_open && (cur_off == run_off);
  assign cnt_next  = run_cnt + 8'd1;
  assign hit_limit = same_off && (cnt_next == CNT_LIMIT);

  always_comb begin
    emit_valid = 1'b0;
    emit_off   = run_off;
    emit_cnt   = run_cnt;
    if (accept) begin
      if (same_off) begin
        if (hit_limit) begin
          emit_valid = 1'b1;
          emit_cnt   = cnt_next;
        end
      end else if (run_open) begin
        emit_valid = 1'b1;
      end
    end else if (flush_take && run_open) begin
      emit_valid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_addr <= '0;
      run_open  <= 1'b0;
      run_off   <= '0;
      run_cnt   <= '0;
    end else if (accept) begin
      prev_addr <= in_addr;
      if (same_off) begin
        if (hit_limit) run_open <= 1'b0;
        else           run_cnt  <= cnt_next;
      end else begin
        run_open <= 1'b1;
        run_off  <= cur_off;
        run_cnt  <= 8'd1;
      end
    end else if (flush_take) begin
      run_open <= 1'b0;
    end
  end

  AST_RUN_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    run_open |-> (run_cnt >= 8'd1 && run_cnt < CNT_LIMIT)); // R8

  AST_EMIT_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    emit_valid |-> (emit_cnt >= 8'd1 && emit_cnt <= CNT_LIMIT)); // R6

  AST_MATCH_SILENT: assert property (@(posedge clk) disable iff (rst)
    (accept && same_off && !hit_limit) |-> !emit_valid); // R11

endmodule

// File: rtl/dve_record_pack.sv
module dve_record_pack
  import dve_pkg::*;
(
  input  off32_t                          off,
  input  logic [7:0]                      cnt,
  output logic [REC_MAX_BYTES-1:0][7:0]   rec_bytes,
  output logic [2:0]                      rec_len
);

  size_code_e code;
  logic [2:0] nb;
  logic       rep;
  logic [2:0] base;

  always_comb begin
    code      = size_of(off);
    nb        = offset_bytes(code);
    rep       = (cnt > 8'd1);
    base      = rep ? 3'd2 : 3'd1;
    rec_bytes = '0;
    rec_bytes[0] = {5'b0, rep, code};
    if (rep) rec_bytes[1] = cnt;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < nb) rec_bytes[int'(base) + k] = off[8*k +: 8];
    end
    rec_len = base + nb;
  end

endmodule

// File: rtl/dve_byte_serializer.sv
module dve_byte_serializer
  import dve_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [REC_MAX_BYTES-1:0][7:0]  ld_bytes,
  input  logic [2:0]                     ld_len,
  input  logic                           out_ready,
  output logic                           out_valid,
  output logic [7:0]                     out_byte
);

  logic [REC_MAX_BYTES-1:0][7:0] sbuf;
  logic [2:0]                    remain;
  logic                          at_hdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sbuf      <= '0;
      remain    <= '0;
      out_valid <= 1'b0;
      at_hdr    <= 1'b0;
    end else if (load) begin
      sbuf      <= ld_bytes;
      remain    <= ld_len;
      out_valid <= 1'b1;
      at_hdr    <= 1'b1;
    end else if (out_valid && out_ready) begin
      for (int i = 0; i < REC_MAX_BYTES - 1; i++) sbuf[i] <= sbuf[i+1];
      sbuf[REC_MAX_BYTES-1] <= 8'h00;
      remain    <= remain - 3'd1;
      out_valid <= (remain != 3'd1);
      at_hdr    <= 1'b0;
    end
  end

  assign out_byte = sbuf[0];

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R10

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !out_valid); // R10

  AST_HDR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && at_hdr) |-> (out_byte[7:3] == 5'd0)); // R2

  AST_SEQ_HDR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (load && ld_bytes[0][2:0] == 3'd0) |-> (ld_len == 3'd1)); // R3

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    load |-> (ld_len >= 3'd1 && ld_len <= 3'd6)); // R4

endmodule

// File: rtl/delta_stream_encoder.sv
module delta_stream_encoder
  import dve_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int RUN_MAX = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte
);

  logic                          accept;
  logic                          flush_take;
  logic                          emit_valid;
  off32_t                        emit_off;
  logic [7:0]                    emit_cnt;
  logic [REC_MAX_BYTES-1:0][7:0] rec_bytes;
  logic [2:0]                    rec_len;

  assign in_ready   = !out_valid;
  assign accept     = in_valid && in_ready;
  assign flush_take = flush && in_ready && !in_valid;

  dve_run_tracker #(
    .ADDR_W  (ADDR_W),
    .RUN_MAX (RUN_MAX)
  ) u_run (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .flush_take (flush_take),
    .in_addr    (in_addr),
    .emit_valid (emit_valid),
    .emit_off   (emit_off),
    .emit_cnt   (emit_cnt)
  );

  dve_record_pack u_pack (
    .off       (emit_off),
    .cnt       (emit_cnt),
    .rec_bytes (rec_bytes),
    .rec_len   (rec_len)
  );

  dve_byte_serializer u_ser (
    .clk       (clk),
    .rst       (rst),
    .load      (emit_valid),
    .ld_bytes  (rec_bytes),
    .ld_len    (rec_len),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte)
  );

  AST_NO_TAKE_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R1

endmodule

// File: tb/delta_stream_encoder_tb.sv
`timescale 1ns/1ps
module delta_stream_encoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        flush = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_byte;

  always #2.5 clk = ~clk;

  delta_stream_encoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .flush(flush), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  int tests = 0;
  int fails = 0;
  int hold_err = 0;
  int stall_mode = 0;
  int ncyc = 0;
  logic [7:0] got[$];
  logic [7:0] exp[$];

  // reference model state
  logic [31:0] m_prev;
  logic        m_open;
  int          m_off;
  int          m_cnt;

  // byte collector and hold checker (negedge sampling)
  logic pv = 1'b0, pr = 1'b1;
  logic [7:0] pb = 8'h00;
  always @(negedge clk) begin
    ncyc++;
    if (!rst) begin
      if (pv && !pr && !(out_valid && out_byte == pb)) hold_err++;
      if (out_valid && in_ready) hold_err++;
    end
    out_ready = (stall_mode == 0) ? 1'b1 : ((ncyc % 3) == 0);
    if (!rst && out_valid && out_ready) got.push_back(out_byte);
    pv = out_valid; pr = out_ready; pb = out_byte;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv, input string what);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic m_emit(input int off, input int cnt);
    int sz;
    int code;
    if (off == 4) begin sz = 0; code = 0; end
    else if (off >= -127 && off <= 127) begin sz = 1; code = 1; end
    else if (off >= -32768 && off <= 32767) begin sz = 2; code = 2; end
    else begin sz = 4; code = 3; end
    exp.push_back(8'((cnt > 1 ? 4 : 0) | code));
    if (cnt > 1) exp.push_back(8'(cnt));
    for (int k = 0; k < sz; k++) exp.push_back(8'(off >> (8*k)));
  endtask

  task automatic m_accept(input logic [31:0] a);
    int d;
    d = int'(a - m_prev);
    m_prev = a;
    if (m_open && d == m_off) begin
      m_cnt++;
      if (m_cnt == 255) begin m_emit(m_off, m_cnt); m_open = 1'b0; end
    end else begin
      if (m_open) m_emit(m_off, m_cnt);
      m_open = 1'b1; m_off = d; m_cnt = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    got.delete(); exp.delete();
    m_prev = '0; m_open = 1'b0; m_off = 0; m_cnt = 0;
  endtask

  task automatic send_addr(input logic [31:0] a);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    in_valid = 1'b1; in_addr = a;
    m_accept(a);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_off(inout logic [31:0] a, input int d);
    a = a + 32'(d);
    send_addr(a);
  endtask

  task automatic do_flush();
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    flush = 1'b1;
    if (m_open) begin m_emit(m_off, m_cnt); m_open = 1'b0; end
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic drain_and_compare(input string tag);
    int idle;
    idle = 0;
    while (idle < 12) begin
      @(negedge clk);
      if (out_valid) idle = 0; else idle++;
    end
    check(tag, 32'(got.size()), 32'(exp.size()), "byte count");
    for (int i = 0; i < got.size() && i < exp.size(); i++)
      check(tag, 32'(got[i]), 32'(exp[i]), $sformatf("byte %0d", i));
    got.delete(); exp.delete();
  endtask

  // R1: reset state, first address measured from zero
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1", 32'(out_valid), 32'd0, "out_valid after reset");
    check("R1", 32'(in_ready), 32'd1, "in_ready after reset");
    send_addr(32'h10);
    do_flush();
    drain_and_compare("R1");
  endtask

  // R3, R6, R2: stride-4 run folded with a count byte
  task automatic t_stride_run();
    do_reset();
    send_addr(32'h100); send_addr(32'h104); send_addr(32'h108);
    send_addr(32'h10C); send_addr(32'h200);
    do_flush();
    drain_and_compare("R6");
  endtask

  // R4, R5: size boundaries, little-endian two's complement
  task automatic t_sizes();
    logic [31:0] a;
    do_reset();
    a = '0;
    send_off(a, 127);    send_off(a, -127);  send_off(a, -128);
    send_off(a, 32767);  send_off(a, -32768); send_off(a, 32768);
    send_off(a, -32769); send_off(a, 0);     send_off(a, 128);
    do_flush();
    drain_and_compare("R4_R5");
  endtask

  // R7, R3: single-reference records, stride 4 as a lone header
  task automatic t_single();
    logic [31:0] a;
    do_reset();
    a = '0;
    send_off(a, 4); send_off(a, 8); send_off(a, 4); send_off(a, 8); send_off(a, 4);
    do_flush();
    drain_and_compare("R7");
  endtask

  // R8: run closes at 255 at once
  task automatic t_saturate();
    logic [31:0] a;
    do_reset();
    a = '0;
    for (int i = 0; i < 254; i++) send_off(a, 8);
    check("R8", 32'(out_valid), 32'd0, "out_valid before limit");
    send_off(a, 8);
    check("R8", 32'(out_valid), 32'd1, "out_valid after 255th");
    check("R8", 32'(out_byte), 32'h05, "header after 255th");
    for (int i = 0; i < 45; i++) send_off(a, 8);
    do_flush();
    drain_and_compare("R8");
  endtask

  // R9: flush with nothing open emits nothing
  task automatic t_flush_empty();
    do_reset();
    do_flush(); do_flush();
    repeat (4) @(negedge clk);
    check("R9", 32'(out_valid), 32'd0, "out_valid after empty flush");
    send_addr(32'h20);
    do_flush(); do_flush();
    drain_and_compare("R9");
  endtask

  // R11: matching reference silent, new difference emits next cycle
  task automatic t_change_timing();
    do_reset();
    send_addr(32'h40);
    check("R11", 32'(out_valid), 32'd0, "first reference held open");
    send_addr(32'h80);
    check("R11", 32'(out_valid), 32'd0, "matching reference silent");
    send_addr(32'h88);
    check("R11", 32'(out_valid), 32'd1, "out_valid after change");
    check("R11", 32'(out_byte), 32'h05, "header after change");
    do_flush();
    drain_and_compare("R11");
  endtask

  // R10: back-pressure holds bytes and blocks input
  task automatic t_stall();
    logic [31:0] a;
    do_reset();
    hold_err = 0;
    stall_mode = 1;
    a = 32'h1000;
    send_addr(a);
    send_off(a, 4); send_off(a, 4); send_off(a, 4);
    send_off(a, -200); send_off(a, -200); send_off(a, 70000);
    send_off(a, 4); send_off(a, 0); send_off(a, 0);
    do_flush();
    drain_and_compare("R10");
    stall_mode = 0;
    check("R10", 32'(hold_err), 32'd0, "hold/ready violations");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: cycles=%0d expected < %0d", 150000, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_stride_run();
    t_sizes();
    t_single();
    t_saturate();
    t_flush_empty();
    t_change_timing();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule